// File: doc/BRIEF.md
# Fractional Sample-Rate Strobe Generator

This block turns one of two master tick streams, one from the 44.1 kHz family and one from the 48 kHz family, into an audio sample-rate strobe. The rate is set by an increment and a modulus. Every selected master tick adds the increment to an accumulator. Each time the accumulator reaches the modulus, the modulus is subtracted and a one-cycle strobe is emitted. The long-run strobe rate is therefore master × inc / mod. With inc fixed at 4, rates from 8 kHz to 48 kHz come out as 4 × master / mod.

Two registers program the block, each with its own write strobe:
- A 16-bit selection word. Its bit 0 picks the master family.
- A 32-bit ratio word. It carries the increment in its low half and a biased form of the modulus in its high half.

One instance serves playback and a second instance serves record. Each codec chooses its generator elsewhere in the chip. The master ticks are single-cycle enables in the block's clock domain.

Top module: `frac_rate_gen`

## Requirements
- R1: Bit 0 of the selection word picks the master. A 1 counts only `tick_44k_i` and a 0 counts only `tick_48k_i`. The unselected tick has no effect, and bits 15:1 of the word are ignored.
- R2: The ratio word holds inc in bits 15:0 and a field in bits 31:16. The modulus is mod = (inc − field − 1) mod 2^16.
- R3: Each selected tick adds inc to the accumulator. If the sum is at least mod, mod is subtracted and a strobe follows. Starting from a cleared accumulator with 1 ≤ inc ≤ mod, N ticks give floor(N·inc/mod) strobes, and the first strobe comes on tick ceil(mod/inc).
- R4: A strobe is high for exactly one clock, in the clock after the edge that samples its tick. Without a tick there is no strobe.
- R5: While mod is zero, the accumulator is held at zero and no strobe is produced.
- R6: A write to either register clears the accumulator. A tick in the same cycle as the write is discarded, so the next period starts fresh.
- R7: After reset the selection bit is 0, inc is 0 and the field is 16'hFFFF, which gives mod = 0. The strobe is low.
- R8: When inc equals mod, every selected tick produces a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_44k_i | input | 1 | Master tick enable, 44.1 kHz family |
| tick_48k_i | input | 1 | Master tick enable, 48 kHz family |
| sel_wr_i | input | 1 | Write strobe for the selection word |
| sel_data_i | input | 16 | Selection word; bit 0 picks the master |
| ratio_wr_i | input | 1 | Write strobe for the ratio word |
| ratio_data_i | input | 32 | {field, inc} ratio word |
| rate_strobe_o | output | 1 | One-cycle sample-rate strobe |

## Verification
The bench builds the block with its default 16-bit divider width and 16-bit selection word. At that width the biased-modulus wrap-around is exercised:
- Reset leaves mod at zero.
- A field equal to inc − 1 also gives mod = 0.
- Real rate ratios such as 4/24 and 4/44 encode to negative 16-bit fields.

The ratio cases are chosen so that exact strobe counts and first-strobe positions can be predicted by floor and ceiling arithmetic.

// File: rtl/frg_pkg.sv
package frg_pkg;
    localparam int DIV_W  = 16;
    localparam int CTRL_W = 16;

    typedef struct packed {
        logic             use_44k;
        logic [DIV_W-1:0] inc;
        logic [DIV_W-1:0] field;
    } frg_cfg_t;

    typedef struct packed {
        logic [DIV_W-1:0] acc;
        logic             strobe;
    } frg_acc_t;
endpackage

// File: rtl/frg_cfg_regs.sv
module frg_cfg_regs
    import frg_pkg::*;
#(
    parameter int P_DIV_W  = DIV_W,
    parameter int P_CTRL_W = CTRL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_wr_i,
    input  logic [P_CTRL_W-1:0]  sel_data_i,
    input  logic                 ratio_wr_i,
    input  logic [2*P_DIV_W-1:0] ratio_data_i,
    output logic                 use_44k_o,
    output logic [P_DIV_W-1:0]   inc_o,
    output logic [P_DIV_W-1:0]   mod_o,
    output logic                 clr_o
);
    localparam int RATIO_W = 2 * P_DIV_W;

    typedef struct packed {
        logic               use_44k;
        logic [P_DIV_W-1:0] inc;
        logic [P_DIV_W-1:0] field;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (sel_wr_i) begin
            cfg_d.use_44k = sel_data_i[0];
        end
        if (ratio_wr_i) begin
            cfg_d.inc   = ratio_data_i[P_DIV_W-1:0];
            cfg_d.field = ratio_data_i[RATIO_W-1:P_DIV_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.use_44k <= 1'b0;
            cfg_q.inc     <= '0;
            cfg_q.field   <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // modulus recovered from the biased field
    assign mod_o     = cfg_q.inc - cfg_q.field - P_DIV_W'(1);
    assign inc_o     = cfg_q.inc;
    assign use_44k_o = cfg_q.use_44k;
    assign clr_o     = sel_wr_i | ratio_wr_i;

    AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_wr_i |=> $stable(use_44k_o)); // R1
    AST_RATIO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !ratio_wr_i |=> ($stable(inc_o) && $stable(mod_o))); // R2
endmodule

// File: rtl/frg_tick_sel.sv
module frg_tick_sel #(
    parameter int N_SRC = 2
) (
    input  logic [N_SRC-1:0]         tick_i,
    input  logic [$clog2(N_SRC)-1:0] pick_i,
    output logic                     tick_o
);
    logic [N_SRC-1:0] gated;

    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_gate
            assign gated[g] = tick_i[g] & (pick_i == g[$clog2(N_SRC)-1:0]);
        end
    endgenerate

    assign tick_o = |gated;
endmodule

// File: rtl/frg_accum.sv
module frg_accum #(
    parameter int P_DIV_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               clr_i,
    input  logic [P_DIV_W-1:0] inc_i,
    input  logic [P_DIV_W-1:0] mod_i,
    output logic               strobe_o
);
    localparam int SUM_W = P_DIV_W + 1;

    typedef struct packed {
        logic [P_DIV_W-1:0] acc;
        logic               strobe;
    } acc_t;

    acc_t st_d, st_q;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] wrapped;

    always_comb begin
        sum     = {1'b0, st_q.acc} + {1'b0, inc_i};
        wrapped = sum - {1'b0, mod_i};
        st_d    = st_q;
        st_d.strobe = 1'b0;
        if (clr_i || (mod_i == '0)) begin
            st_d.acc = '0;
        end else if (tick_i) begin
            if (sum >= {1'b0, mod_i}) begin
                st_d.acc    = wrapped[P_DIV_W-1:0];
                st_d.strobe = 1'b1;
            end else begin
                st_d.acc = sum[P_DIV_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe_o = st_q.strobe;

    AST_STROBE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> $past(tick_i)); // R4
    AST_ACC_BELOW_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        ((mod_i != '0) && (inc_i <= mod_i)) |-> (st_q.acc < mod_i)); // R3
    AST_ZERO_MOD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_i == '0) |-> ((st_q.acc == '0) && !strobe_o)); // R5
    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ((st_q.acc == '0) && !strobe_o)); // R6
endmodule

// File: rtl/frac_rate_gen.sv
module frac_rate_gen
    import frg_pkg::*;
#(
    parameter int P_DIV_W  = DIV_W,
    parameter int P_CTRL_W = CTRL_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_44k_i,
    input  logic                 tick_48k_i,
    input  logic                 sel_wr_i,
    input  logic [P_CTRL_W-1:0]  sel_data_i,
    input  logic                 ratio_wr_i,
    input  logic [2*P_DIV_W-1:0] ratio_data_i,
    output logic                 rate_strobe_o
);
    logic               use_44k;
    logic [P_DIV_W-1:0] inc;
    logic [P_DIV_W-1:0] mod;
    logic               clr;
    logic               tick;

    frg_cfg_regs #(.P_DIV_W(P_DIV_W), .P_CTRL_W(P_CTRL_W)) cfg_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_wr_i     (sel_wr_i),
        .sel_data_i   (sel_data_i),
        .ratio_wr_i   (ratio_wr_i),
        .ratio_data_i (ratio_data_i),
        .use_44k_o    (use_44k),
        .inc_o        (inc),
        .mod_o        (mod),
        .clr_o        (clr)
    );

    // source 1 is the 44.1 kHz family, source 0 the 48 kHz family
    frg_tick_sel #(.N_SRC(2)) sel_i (
        .tick_i ({tick_44k_i, tick_48k_i}),
        .pick_i (use_44k),
        .tick_o (tick)
    );

    frg_accum #(.P_DIV_W(P_DIV_W)) acc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .clr_i    (clr),
        .inc_i    (inc),
        .mod_i    (mod),
        .strobe_o (rate_strobe_o)
    );

    AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick_44k_i || tick_48k_i) |=> !rate_strobe_o); // R4
endmodule

// File: tb/frac_rate_gen_tb_top.sv
module frac_rate_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;
    localparam int V_SEL [NV] = '{1, 0, 0, 1, 0, 1};
    localparam int V_INC [NV] = '{4, 4, 4, 3, 5, 4};
    localparam int V_MOD [NV] = '{20, 8, 4, 7, 17, 44};
    localparam int V_N   [NV] = '{100, 48, 10, 70, 68, 88};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_44k_i = 1'b0;
    logic        tick_48k_i = 1'b0;
    logic        sel_wr_i = 1'b0;
    logic [15:0] sel_data_i = '0;
    logic        ratio_wr_i = 1'b0;
    logic [31:0] ratio_data_i = '0;
    logic        rate_strobe_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frac_rate_gen dut_i (
        .clk(clk), .rst_n(rst_n), .tick_44k_i(tick_44k_i), .tick_48k_i(tick_48k_i),
        .sel_wr_i(sel_wr_i), .sel_data_i(sel_data_i), .ratio_wr_i(ratio_wr_i),
        .ratio_data_i(ratio_data_i), .rate_strobe_o(rate_strobe_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic tick_once(input logic t44, input logic t48, output logic s);
        tick_44k_i = t44;
        tick_48k_i = t48;
        @(negedge clk);
        s = rate_strobe_o;
        tick_44k_i = 1'b0;
        tick_48k_i = 1'b0;
    endtask

    task automatic write_sel(input logic [15:0] v);
        sel_wr_i = 1'b1;
        sel_data_i = v;
        @(negedge clk);
        sel_wr_i = 1'b0;
    endtask

    task automatic write_ratio(input int inc, input int md);
        logic [15:0] fld;
        fld = 16'(inc - md - 1);
        ratio_wr_i = 1'b1;
        ratio_data_i = {fld, 16'(inc)};
        @(negedge clk);
        ratio_wr_i = 1'b0;
    endtask

    // runs n ticks, returns strobe count and first strobe tick (0 if none)
    task automatic run_ticks(input logic t44, input logic t48, input int n,
                             output int cnt, output int first);
        logic s;
        cnt = 0;
        first = 0;
        for (int k = 1; k <= n; k++) begin
            tick_once(t44, t48, s);
            if (s) begin
                cnt++;
                if (first == 0) first = k;
            end
        end
    endtask

    initial begin
        int cnt, first;
        logic s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 reset state: strobe low, mod zero so ticks on both lines do nothing
        check("R7 strobe after reset", int'(rate_strobe_o), 0);
        run_ticks(1'b1, 1'b1, 20, cnt, first);
        check("R7 no strobe with reset mod", cnt, 0);

        // vector table: R3 counts and first-strobe positions, R1 selected source
        for (int v = 0; v < NV; v++) begin
            write_sel(16'(V_SEL[v]));
            write_ratio(V_INC[v], V_MOD[v]);
            run_ticks(V_SEL[v] == 1, V_SEL[v] == 0, V_N[v], cnt, first);
            check($sformatf("R3 count vec%0d", v), cnt, (V_N[v] * V_INC[v]) / V_MOD[v]);
            check($sformatf("R3 first vec%0d", v), first,
                  (V_MOD[v] + V_INC[v] - 1) / V_INC[v]);
        end

        // R8 inc equal mod: strobe every tick
        write_sel(16'h0000);
        write_ratio(6, 6);
        run_ticks(1'b0, 1'b1, 12, cnt, first);
        check("R8 strobe per tick", cnt, 12);

        // R4 one-cycle width: idle cycle after a strobe is low
        tick_once(1'b0, 1'b1, s);
        check("R4 strobe on tick", int'(s), 1);
        @(negedge clk);
        check("R4 strobe drops", int'(rate_strobe_o), 0);

        // R1 unselected tick ignored, and it leaves the accumulator untouched
        write_sel(16'h0001);
        write_ratio(4, 24);
        run_ticks(1'b0, 1'b1, 30, cnt, first);
        check("R1 48k ignored when 44k selected", cnt, 0);
        run_ticks(1'b1, 1'b0, 6, cnt, first);
        check("R1 accumulator untouched by unselected tick", first, 6);

        // R1 upper bits of the selection word ignored: 16'hFFFE selects 48k
        write_sel(16'hFFFE);
        write_ratio(4, 4);
        run_ticks(1'b1, 1'b0, 10, cnt, first);
        check("R1 upper bits ignored, 44k idle", cnt, 0);
        run_ticks(1'b0, 1'b1, 10, cnt, first);
        check("R1 upper bits ignored, 48k counts", cnt, 10);

        // R2 field equal inc-1 gives mod zero; R5 holds idle
        write_ratio(4, 0);
        run_ticks(1'b0, 1'b1, 40, cnt, first);
        check("R5 zero modulus idle", cnt, 0);

        // R2 large modulus from the field wrap: inc 1, mod 300
        write_ratio(1, 300);
        run_ticks(1'b0, 1'b1, 300, cnt, first);
        check("R2 mod 300 first strobe", first, 300);

        // R6 rewrite mid-period clears the accumulator
        write_ratio(4, 24);
        run_ticks(1'b0, 1'b1, 5, cnt, first);
        write_ratio(4, 24);
        run_ticks(1'b0, 1'b1, 6, cnt, first);
        check("R6 rewrite restarts period", first, 6);

        // R6 tick coinciding with a write is discarded
        run_ticks(1'b0, 1'b1, 5, cnt, first);
        ratio_wr_i = 1'b1;
        ratio_data_i = {16'(4 - 24 - 1), 16'd4};
        tick_once(1'b0, 1'b1, s);
        ratio_wr_i = 1'b0;
        check("R6 no strobe on write cycle", int'(s), 0);
        run_ticks(1'b0, 1'b1, 6, cnt, first);
        check("R6 tick with write discarded", first, 6);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule